// File: doc/BRIEF.md
# Transparent Bit-Serial Transmitter with Error Abort

This block sends raw 16-bit words as a continuous bit stream, most significant bit first, one bit per clock. A producer writes words into a four-entry queue over a valid/ready port. Each word carries two flags. The end-of-buffer flag marks the final word of a buffer. The final-buffer flag marks a buffer after which synchronization ends. Words wait in the queue until a sync command puts the transmitter into its running state. From then on, words leave back to back with no gap between them.

While running, the block watches the queue level and a clear-to-send input. Two error cases abort the transfer. The first is an empty queue at the moment the next word is needed. The second is clear-to-send dropping while bits are being shifted and the line is not under software control. On an abort the block closes the buffer with a status pulse, flushes the queue, sets a sticky error flag and halts. In the halted state the line stays at mark. Only a restart command resumes transmission. A stop command ends transmission at once from any active state.

The error flag drives the interrupt output through an enable input. Software clears the flag by pulsing a write-one-to-clear input.

Top module: `txp_serial_tx`

## Requirements
- R1: The queue holds four words. A word is accepted at a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while four words are held. `in_ready` is also 0 in a cycle where an abort or stop flushes the queue.
- R2: After reset, `txd`=1, `in_ready`=1, `buf_close`=0 and `err_pend`=0.
- R3: Outside the running state, `txd` is 1 and queued words are not sent.
- R4: In the running state with the shifter free and the queue not empty, a word is loaded and its bits appear on `txd` MSB first, one per clock. From idle, the first bit appears in the second cycle after the sync command. A following queued word starts in the cycle right after the previous word's last bit.
- R5: One cycle after the last bit of a word with the end-of-buffer flag, `buf_close` pulses for one cycle with `stat_un`=0 and `stat_ct`=0. If that word also carries the final-buffer flag, the block returns to idle and needs a new sync command.
- R6: Mid-buffer underrun: the queue is empty when a word without the end-of-buffer flag ends. One cycle later `buf_close`=1, `stat_un`=1, `stat_ct`=0 and `err_pend`=1, and the block halts.
- R7: The queue is empty when a word ends that has the end-of-buffer flag but not the final-buffer flag. The buffer closes normally (`stat_un`=0) and `err_pend` becomes 1 in the same cycle. The block halts.
- R8: With `sw_cts`=0, `cts`=0 seen at a clock edge while bits are shifting aborts the transfer. In the next cycle `txd`=1, `buf_close`=1, `stat_ct`=1, `stat_un`=0 and `err_pend`=1. The queue is emptied and the block halts.
- R9: With `sw_cts`=1, the value of `cts` has no effect on transmission.
- R10: While halted, queued words are not sent until `cmd_restart` is pulsed. After the restart, sending resumes with the same timing as after a sync command.
- R11: `cmd_stop` in the running or halted state forces `txd`=1 in the next cycle without a buffer close. It empties the queue and returns to idle.
- R12: `err_irq` = `err_pend` AND `err_ien`. A pulse on `err_clr` clears `err_pend`. A new error in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Producer has a word |
| in_ready | output | 1 | Queue can take a word |
| in_data | input | 16 | Word to send |
| in_eob | input | 1 | Word ends its buffer |
| in_last | input | 1 | Buffer is the final one (use with in_eob) |
| sync_go | input | 1 | Pulse: leave idle and start running |
| cmd_restart | input | 1 | Pulse: leave halted state and run |
| cmd_stop | input | 1 | Pulse: end transmission, go idle |
| cts | input | 1 | Clear-to-send, 1 = clear |
| sw_cts | input | 1 | 1 = ignore cts |
| err_ien | input | 1 | Error interrupt enable |
| err_clr | input | 1 | Pulse: clear error flag |
| txd | output | 1 | Serial data, 1 when idle |
| buf_close | output | 1 | One-cycle buffer-closed pulse |
| stat_un | output | 1 | Underrun status, valid with buf_close |
| stat_ct | output | 1 | Clear-to-send-lost status, valid with buf_close |
| err_pend | output | 1 | Sticky error flag |
| err_irq | output | 1 | Error interrupt |

## Verification
The assertions assume that the command inputs are single-cycle pulses and that sync and restart are issued only in the state that accepts them. They also assume that `in_valid` is not held while `in_ready` is low, so the queue count stays within four. The stimulus meets these assumptions. It drives every input at the falling edge and raises `in_valid` only after it has seen `in_ready` high. It issues exactly one command per pulse, always from a known state. It changes `cts` only while the line is shifting or idle, never during the cycle of a load decision.

// File: rtl/txp_pkg.sv
package txp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/txp_fifo.sv
module txp_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  // the controller never takes a word from an empty queue
  p_no_pop_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/txp_shift.sv
module txp_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clr,
  input  logic [DW-1:0] ldata,
  output logic          txd,
  output logic          busy,
  output logic          last_bit
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (clr) begin
      cnt  <= '0;
    end else if (load) begin
      sreg <= ldata;
      cnt  <= CW'(DW);
    end else if (busy) begin
      sreg <= {sreg[DW-2:0], 1'b0};
      cnt  <= cnt - 1'b1;
    end
  end

  assign busy     = (cnt != '0);
  assign last_bit = (cnt == CW'(1));
  assign txd      = busy ? sreg[DW-1] : 1'b1;

  // a new word only enters a free shifter or one on its final bit
  p_load_when_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!busy || last_bit));
endmodule

// File: rtl/txp_ctrl.sv
module txp_ctrl
  import txp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_go,
  input  logic      cmd_restart,
  input  logic      cmd_stop,
  input  logic      cts,
  input  logic      sw_cts,
  input  logic      err_clr,
  input  logic      q_empty,
  input  logic      q_eob,
  input  logic      q_last,
  input  logic      sh_busy,
  input  logic      sh_end,
  output logic      ld,
  output logic      sh_clr,
  output logic      flush,
  output tx_state_e state,
  output logic      buf_close,
  output logic      stat_un,
  output logic      stat_ct,
  output logic      err_pend
);
  tx_state_e state_q, nxt;
  logic cur_eob_q, cur_last_q;
  logic close_d, un_d, ct_d, err_d;
  logic stop_hit, cts_hit, running;

  assign running  = (state_q == ST_RUN);
  assign stop_hit = cmd_stop && (state_q != ST_IDLE);
  assign cts_hit  = running && sh_busy && !sw_cts && !cts;

  always_comb begin
    nxt     = state_q;
    ld      = 1'b0;
    sh_clr  = 1'b0;
    flush   = 1'b0;
    close_d = 1'b0;
    un_d    = 1'b0;
    ct_d    = 1'b0;
    err_d   = 1'b0;
    if (stop_hit) begin
      nxt    = ST_IDLE;
      sh_clr = 1'b1;
      flush  = 1'b1;
    end else if (cts_hit) begin
      nxt     = ST_HALT;
      sh_clr  = 1'b1;
      flush   = 1'b1;
      close_d = 1'b1;
      ct_d    = 1'b1;
      err_d   = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (sync_go) nxt = ST_RUN;
        ST_HALT: if (cmd_restart) nxt = ST_RUN;
        ST_RUN: begin
          if (sh_end) begin
            if (cur_eob_q) begin
              close_d = 1'b1;
              if (cur_last_q) begin
                nxt = ST_IDLE;
              end else if (!q_empty) begin
                ld = 1'b1;
              end else begin
                // gap between buffers: flag only
                err_d = 1'b1;
                nxt   = ST_HALT;
                flush = 1'b1;
              end
            end else if (!q_empty) begin
              ld = 1'b1;
            end else begin
              close_d = 1'b1;
              un_d    = 1'b1;
              err_d   = 1'b1;
              nxt     = ST_HALT;
              flush   = 1'b1;
            end
          end else if (!sh_busy && !q_empty) begin
            ld = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_eob_q  <= 1'b0;
      cur_last_q <= 1'b0;
      buf_close  <= 1'b0;
      stat_un    <= 1'b0;
      stat_ct    <= 1'b0;
      err_pend   <= 1'b0;
    end else begin
      state_q   <= nxt;
      buf_close <= close_d;
      stat_un   <= un_d;
      stat_ct   <= ct_d;
      if (ld) begin
        cur_eob_q  <= q_eob;
        cur_last_q <= q_last;
      end
      if (err_d)        err_pend <= 1'b1;
      else if (err_clr) err_pend <= 1'b0;
    end
  end

  assign state = state_q;

  p_close_cause_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_close |-> $onehot0({stat_un, stat_ct}));

  p_abort_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_close && (stat_un || stat_ct)) |-> (state_q == ST_HALT));

  p_swmode_no_ct_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_close && stat_ct) |-> !$past(sw_cts));

  p_err_enters_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pend) |-> (state_q == ST_HALT));
endmodule

// File: rtl/txp_serial_tx.sv
module txp_serial_tx
  import txp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_eob,
  input  logic          in_last,
  input  logic          sync_go,
  input  logic          cmd_restart,
  input  logic          cmd_stop,
  input  logic          cts,
  input  logic          sw_cts,
  input  logic          err_ien,
  input  logic          err_clr,
  output logic          txd,
  output logic          buf_close,
  output logic          stat_un,
  output logic          stat_ct,
  output logic          err_pend,
  output logic          err_irq
);
  localparam int EW = DW + 2;

  logic          q_full, q_empty, push, ld, sh_clr, flush, sh_busy, sh_end;
  logic [EW-1:0] q_rdata;
  tx_state_e     state;

  assign in_ready = !q_full && !flush;
  assign push     = in_valid && in_ready;

  txp_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (ld),
    .flush (flush),
    .wdata ({in_last, in_eob, in_data}),
    .rdata (q_rdata),
    .empty (q_empty),
    .full  (q_full)
  );

  txp_shift #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .clr      (sh_clr),
    .ldata    (q_rdata[DW-1:0]),
    .txd      (txd),
    .busy     (sh_busy),
    .last_bit (sh_end)
  );

  txp_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_go     (sync_go),
    .cmd_restart (cmd_restart),
    .cmd_stop    (cmd_stop),
    .cts         (cts),
    .sw_cts      (sw_cts),
    .err_clr     (err_clr),
    .q_empty     (q_empty),
    .q_eob       (q_rdata[DW]),
    .q_last      (q_rdata[DW+1]),
    .sh_busy     (sh_busy),
    .sh_end      (sh_end),
    .ld          (ld),
    .sh_clr      (sh_clr),
    .flush       (flush),
    .state       (state),
    .buf_close   (buf_close),
    .stat_un     (stat_un),
    .stat_ct     (stat_ct),
    .err_pend    (err_pend)
  );

  assign err_irq = err_pend && err_ien;

  // outside the running state the line rests at mark
  p_idle_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |-> txd);
endmodule

// File: tb/txp_serial_tx_tb_top.sv
module txp_serial_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_eob = 0, in_last = 0;
  logic [15:0] in_data = '0;
  logic sync_go = 0, cmd_restart = 0, cmd_stop = 0;
  logic cts = 1, sw_cts = 0, err_ien = 1, err_clr = 0;
  logic in_ready, txd, buf_close, stat_un, stat_ct, err_pend, err_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] q_data [4];

  localparam logic [15:0] TV [6] = '{16'hA5C3, 16'h0001, 16'h8000,
                                     16'hFFFF, 16'h0000, 16'h3C96};

  always #2 clk = ~clk;

  txp_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_eob(in_eob), .in_last(in_last),
    .sync_go(sync_go), .cmd_restart(cmd_restart), .cmd_stop(cmd_stop),
    .cts(cts), .sw_cts(sw_cts), .err_ien(err_ien), .err_clr(err_clr),
    .txd(txd), .buf_close(buf_close), .stat_un(stat_un), .stat_ct(stat_ct),
    .err_pend(err_pend), .err_irq(err_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int idx, input logic [15:0] d, input logic eob, input logic lst);
    chk(in_ready == 1'b1, "R1 ready before push", int'(in_ready), 1);
    q_data[idx] = d;
    in_valid = 1; in_data = d; in_eob = eob; in_last = lst;
    @(negedge clk);
    in_valid = 0; in_eob = 0; in_last = 0;
  endtask

  task automatic issue(input bit restart);
    if (restart) cmd_restart = 1; else sync_go = 1;
    @(negedge clk);
    cmd_restart = 0; sync_go = 0;
    chk(txd == 1'b1, "R4 gap cycle", int'(txd), 1);
  endtask

  task automatic expect_bits(input int nw, input int cut);
    int n = 0;
    for (int w = 0; w < nw; w++) begin
      for (int b = 15; b >= 0; b--) begin
        if (cut >= 0 && n == cut) return;
        @(negedge clk);
        chk(txd == q_data[w][b], "R4 serial bit", int'(txd), int'(q_data[w][b]));
        n++;
      end
    end
  endtask

  task automatic expect_close(input logic un, input logic ct, input logic pend, input string req);
    @(negedge clk);
    chk(buf_close == 1'b1, req, int'(buf_close), 1);
    chk(stat_un == un, req, int'(stat_un), int'(un));
    chk(stat_ct == ct, req, int'(stat_ct), int'(ct));
    chk(err_pend == pend, req, int'(err_pend), int'(pend));
    chk(txd == 1'b1, req, int'(txd), 1);
  endtask

  task automatic hold_mark(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(txd == 1'b1, req, int'(txd), 1);
    end
  endtask

  task automatic clear_err();
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk(err_pend == 1'b0, "R12 write-one clear", int'(err_pend), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk(txd == 1'b1, "R2 txd", int'(txd), 1);
    chk(in_ready == 1'b1, "R2 in_ready", int'(in_ready), 1);
    chk(buf_close == 1'b0, "R2 buf_close", int'(buf_close), 0);
    chk(err_pend == 1'b0, "R2 err_pend", int'(err_pend), 0);

    // table walk: single-word final buffers (R3, R4, R5)
    for (int v = 0; v < 6; v++) begin
      push(0, TV[v], 1, 1);
      hold_mark(3, "R3 idle holds word");
      issue(0);
      expect_bits(1, -1);
      expect_close(0, 0, 0, "R5 normal close");
      hold_mark(3, "R5 final buffer returns idle");
    end

    // four-word buffer, back to back; queue full (R1, R4)
    push(0, 16'h1234, 0, 0);
    push(1, 16'hFEDC, 0, 0);
    push(2, 16'h0F0F, 0, 0);
    push(3, 16'hB00B, 1, 1);
    chk(in_ready == 1'b0, "R1 full after four", int'(in_ready), 0);
    issue(0);
    expect_bits(4, -1);
    expect_close(0, 0, 0, "R5 close after 4 words");

    // mid-buffer underrun (R6), halt (R10), irq gating (R12)
    push(0, 16'hC001, 0, 0);
    issue(0);
    expect_bits(1, -1);
    expect_close(1, 0, 1, "R6 mid-buffer underrun");
    chk(err_irq == 1'b1, "R12 irq enabled", int'(err_irq), 1);
    push(0, 16'h5AA5, 1, 1);
    hold_mark(20, "R10 halted waits restart");
    err_ien = 0;
    @(negedge clk);
    chk(err_irq == 1'b0, "R12 irq masked", int'(err_irq), 0);
    chk(err_pend == 1'b1, "R12 flag sticky", int'(err_pend), 1);
    err_ien = 1;
    clear_err();
    issue(1);
    expect_bits(1, -1);
    expect_close(0, 0, 0, "R10 resumed after restart");

    // underrun between buffers: flag only (R7)
    push(0, 16'h6789, 1, 0);
    issue(0);
    expect_bits(1, -1);
    expect_close(0, 0, 1, "R7 gap underrun flag only");
    clear_err();
    push(0, 16'h2468, 1, 1);
    issue(1);
    expect_bits(1, -1);
    expect_close(0, 0, 0, "R7 recover");

    // clear-to-send lost mid-word (R8), queue flushed
    push(0, 16'hACE1, 0, 0);
    push(1, 16'h1357, 1, 1);
    issue(0);
    expect_bits(1, 6);
    cts = 0;
    expect_close(0, 1, 1, "R8 cts lost abort");
    cts = 1;
    clear_err();
    push(0, 16'h0102, 0, 0);
    push(1, 16'h0304, 0, 0);
    push(2, 16'h0506, 0, 0);
    push(3, 16'h0708, 1, 1);
    chk(in_ready == 1'b0, "R8 flushed queue refills to four", int'(in_ready), 0);
    issue(1);
    expect_bits(4, -1);
    expect_close(0, 0, 0, "R8 recover");

    // software control ignores cts (R9)
    sw_cts = 1; cts = 0;
    push(0, 16'h9C3A, 1, 1);
    issue(0);
    expect_bits(1, -1);
    expect_close(0, 0, 0, "R9 cts ignored");
    cts = 1; sw_cts = 0;

    // stop command (R11)
    push(0, 16'hF00D, 0, 0);
    push(1, 16'hBEEF, 1, 1);
    issue(0);
    expect_bits(1, 4);
    cmd_stop = 1;
    @(negedge clk);
    cmd_stop = 0;
    chk(txd == 1'b1, "R11 stop mark", int'(txd), 1);
    chk(buf_close == 1'b0, "R11 no close on stop", int'(buf_close), 0);
    chk(err_pend == 1'b0, "R11 no error on stop", int'(err_pend), 0);
    hold_mark(5, "R11 idle after stop");
    push(0, 16'h4321, 0, 0);
    push(1, 16'h8765, 0, 0);
    push(2, 16'hCBA9, 0, 0);
    push(3, 16'h0FED, 1, 1);
    chk(in_ready == 1'b0, "R11 flushed queue refills to four", int'(in_ready), 0);
    hold_mark(4, "R11 needs sync");
    issue(0);
    expect_bits(4, -1);
    expect_close(0, 0, 0, "R11 resumed by sync");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule